// File: doc/BRIEF.md
# Coprocessor Register Transfer Controller

This block is the coprocessor-side half of a handshake for single-register moves between a host integer pipeline and a coprocessor. The host marks each pipeline advance by pulling an active-low request strobe low. It presents an instruction word with each advance. The controller decodes whether the word is a register move addressed to this coprocessor, and whether it is a read or a write. It answers at once on a two-bit decode handshake. It then follows the instruction through execute, memory and write stages, in step with the host.

In the first execute cycle the host reports whether the condition passed. A failed condition drops the instruction without a trace. A passing instruction is paced by a second handshake bus: WAIT stalls the host and LAST commits the move. The number of stall responses is a parameter. After the commit the memory and write stages follow on consecutive cycles. A read places register contents on the read-data bus during the memory stage. A write latches the host's data in the write stage unless the host raised late-cancel during the memory stage. Sixteen 32-bit registers are held locally.

Top module: `cpRegXfer`

## Requirements
- R1: Handshake codes are 00 absent, 01 wait, 10 go, 11 last. In a cycle with `reqN` low whose `instr[11:8]` equals parameter `CpNum`, `hsDecode` is wait (or last when `NumWaits` is 0) in that same cycle. Otherwise `hsDecode` is absent.
- R2: `instr[20]` set means a read from the coprocessor and clear means a write to it. `instr[19:16]` selects one of 16 registers, and only that register is affected.
- R3: If `condPass` is low in the first execute cycle (the next cycle with `reqN` low after decode), the instruction is dropped. `hsExec` stays absent, `cpRdData` stays zero and no register changes.
- R4: After a passing first execute cycle, `hsExec` answers wait in each following cycle until `NumWaits` wait answers (the decode answer included) have been given. It then answers last for exactly one cycle.
- R5: For a write, the value on `hostWrData` in the write stage is stored. The write stage is two cycles after the cycle that gave last.
- R6: For a read, `cpRdData` carries the addressed register during the memory stage, the cycle after last. At all other times it is zero.
- R7: `lateCancel` high during a write's memory stage discards that write and leaves the register unchanged.
- R8: A second instruction may be decoded while the first is in execute. It enters its own execute stage at the host's next advance, and a read then returns data written by the earlier instruction.
- R9: When a read's memory stage coincides with a write stage to the same register (only possible with `NumWaits` of 0), `cpRdData` returns the value being written.
- R10: After reset, all registers are zero, both handshakes are absent and `cpRdData` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqN | input | 1 | Active-low pipeline advance / instruction-present strobe |
| instr | input | 32 | Instruction word entering decode |
| condPass | input | 1 | Condition passed, valid in the first execute cycle |
| lateCancel | input | 1 | Discard the instruction in memory stage |
| hostWrData | input | 32 | Host write data, valid in write stage |
| hsDecode | output | 2 | Decode-stage handshake answer |
| hsExec | output | 2 | Execute-stage handshake answer |
| cpRdData | output | 32 | Read data for the host, valid in memory stage |

## Verification
Assertions guard several properties on every cycle: the idle decode answer, the single-cycle last followed by entry to memory, the effect of a failed condition on the next cycle, the blocking of writes by late-cancel, and the landing of written data in the addressed register. Only the directed scenarios can show end-to-end data movement. These are a write followed by a read of the same and other registers, the invisibility of a dropped or cancelled write, a second instruction decoded during the first one's stalls, and same-cycle forwarding in the zero-wait configuration.

// File: rtl/cpXferPkg.sv
package cpXferPkg;
  localparam int IdxW = 4;

  typedef enum logic [1:0] {
    HS_ABSENT = 2'b00,
    HS_WAIT   = 2'b01,
    HS_GO     = 2'b10,
    HS_LAST   = 2'b11
  } hsCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic            wrEn;
    logic [IdxW-1:0] wrIdx;
    logic            rdEn;
    logic [IdxW-1:0] rdIdx;
  } dpStrobe_t;
endpackage

// File: rtl/cpXferCtrl.sv
module cpXferCtrl
  import cpXferPkg::*;
#(
  parameter int CpNum    = 6,
  parameter int NumWaits = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqN,
  input  logic [31:0] instr,
  input  logic        condPass,
  input  logic        lateCancel,
  output hsCode_e     hsDecode,
  output hsCode_e     hsExec,
  output dpStrobe_t   strobe
);
  localparam logic [3:0] CpId = 4'(CpNum);
  localparam int CntW = (NumWaits > 0) ? $clog2(NumWaits + 1) : 1;

  logic            owned;
  logic            instrRead;
  logic [IdxW-1:0] instrIdx;
  logic            unusedInstr;

  assign owned       = (instr[11:8] == CpId);
  assign instrRead   = instr[20];
  assign instrIdx    = instr[19:16];
  assign unusedInstr = ^{instr[31:21], instr[15:12], instr[7:0]};

  // decode-stage answer, same cycle
  always_comb begin
    if (!reqN && owned) hsDecode = (NumWaits == 0) ? HS_LAST : HS_WAIT;
    else                hsDecode = HS_ABSENT;
  end

  // decode stage register
  logic            decValid, decRead;
  logic [IdxW-1:0] decIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decValid <= 1'b0;
      decRead  <= 1'b0;
      decIdx   <= '0;
    end else if (!reqN) begin
      decValid <= owned;
      decRead  <= instrRead;
      decIdx   <= instrIdx;
    end
  end

  logic firstExec, go;
  assign firstExec = !reqN && decValid;
  assign go        = firstExec && condPass;

  // execute stage
  logic            exWaiting;
  logic [CntW-1:0] waitCnt;
  logic            lastNow;
  logic            commit, commitRead;
  logic [IdxW-1:0] commitIdx;

  assign lastNow = exWaiting && (waitCnt == CntW'(NumWaits));

  always_comb begin
    if (!exWaiting)   hsExec = HS_ABSENT;
    else if (lastNow) hsExec = HS_LAST;
    else              hsExec = HS_WAIT;
  end

  generate
    if (NumWaits == 0) begin : gZeroWait
      assign exWaiting  = 1'b0;
      assign waitCnt    = '0;
      assign commit     = go;
      assign commitRead = decRead;
      assign commitIdx  = decIdx;
    end else begin : gPaced
      logic            exRead;
      logic [IdxW-1:0] exIdx;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          exWaiting <= 1'b0;
          waitCnt   <= '0;
          exRead    <= 1'b0;
          exIdx     <= '0;
        end else if (go && !exWaiting) begin
          exWaiting <= 1'b1;
          waitCnt   <= CntW'(1);
          exRead    <= decRead;
          exIdx     <= decIdx;
        end else if (lastNow) begin
          exWaiting <= 1'b0;
        end else if (exWaiting) begin
          waitCnt   <= waitCnt + CntW'(1);
        end
      end

      assign commit     = lastNow;
      assign commitRead = exRead;
      assign commitIdx  = exIdx;
    end
  endgenerate

  // memory and write stages
  logic            memValid, memRead, wrValid;
  logic [IdxW-1:0] memIdx, wrIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memValid <= 1'b0;
      memRead  <= 1'b0;
      memIdx   <= '0;
      wrValid  <= 1'b0;
      wrIdx    <= '0;
    end else begin
      memValid <= commit;
      memRead  <= commitRead;
      memIdx   <= commitIdx;
      wrValid  <= memValid && !memRead && !lateCancel;
      wrIdx    <= memIdx;
    end
  end

  always_comb begin
    strobe.rdEn  = memValid && memRead;
    strobe.rdIdx = memIdx;
    strobe.wrEn  = wrValid;
    strobe.wrIdx = wrIdx;
  end

  assert_no_decode_when_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqN |-> hsDecode == HS_ABSENT);

  assert_fail_drops_R3: assert property (@(posedge clk) disable iff (!rstN)
    (firstExec && !condPass && !exWaiting) |=> (hsExec == HS_ABSENT && !memValid));

  assert_single_last_R4: assert property (@(posedge clk) disable iff (!rstN)
    (hsExec == HS_LAST) |=> (hsExec == HS_ABSENT));

  assert_last_to_memory_R6: assert property (@(posedge clk) disable iff (!rstN)
    (hsExec == HS_LAST) |=> memValid);

  assert_cancel_blocks_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && lateCancel) |=> !wrValid);
endmodule

// File: rtl/cpXferDatapath.sv
module cpXferDatapath
  import cpXferPkg::*;
#(
  parameter int DataW = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [DataW-1:0] hostWrData,
  output logic [DataW-1:0] cpRdData
);
  localparam int RegCount = 1 << IdxW;

  logic [DataW-1:0] regs [RegCount];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < RegCount; i++) regs[i] <= '0;
    end else if (strobe.wrEn) begin
      regs[strobe.wrIdx] <= hostWrData;
    end
  end

  // read with forwarding from a write stage in the same cycle
  always_comb begin
    if (!strobe.rdEn)
      cpRdData = '0;
    else if (strobe.wrEn && (strobe.wrIdx == strobe.rdIdx))
      cpRdData = hostWrData;
    else
      cpRdData = regs[strobe.rdIdx];
  end

  assert_write_lands_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |=> regs[$past(strobe.wrIdx)] == $past(hostWrData));
endmodule

// File: rtl/cpRegXfer.sv
module cpRegXfer
  import cpXferPkg::*;
#(
  parameter int CpNum    = 6,
  parameter int NumWaits = 2,
  parameter int DataW    = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqN,
  input  logic [31:0]      instr,
  input  logic             condPass,
  input  logic             lateCancel,
  input  logic [DataW-1:0] hostWrData,
  output logic [1:0]       hsDecode,
  output logic [1:0]       hsExec,
  output logic [DataW-1:0] cpRdData
);
  hsCode_e   decCode, exCode;
  dpStrobe_t strobe;

  cpXferCtrl #(.CpNum(CpNum), .NumWaits(NumWaits)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqN(reqN), .instr(instr),
    .condPass(condPass), .lateCancel(lateCancel),
    .hsDecode(decCode), .hsExec(exCode), .strobe(strobe)
  );

  cpXferDatapath #(.DataW(DataW)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .hostWrData(hostWrData), .cpRdData(cpRdData)
  );

  assign hsDecode = decCode;
  assign hsExec   = exCode;
endmodule

// File: tb/cpRegXfer_tb_top.sv
module cpRegXfer_tb_top;
  localparam int ClkPeriod = 10;
  localparam int CpNum = 6;
  localparam logic [1:0] ABS = 2'b00, WT = 2'b01, LST = 2'b11;

  logic        clk = 1'b0, rstN = 1'b0, reqN = 1'b1;
  logic [31:0] instr = '0, hostWrData = '0;
  logic        condPass = 1'b0, lateCancel = 1'b0;
  logic [1:0]  hsDecode, hsExec, hsDecodeZ, hsExecZ;
  logic [31:0] cpRdData, cpRdDataZ;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(ClkPeriod/2) clk = ~clk;

  cpRegXfer #(.CpNum(CpNum), .NumWaits(2)) dut_i (
    .clk(clk), .rstN(rstN), .reqN(reqN), .instr(instr), .condPass(condPass),
    .lateCancel(lateCancel), .hostWrData(hostWrData),
    .hsDecode(hsDecode), .hsExec(hsExec), .cpRdData(cpRdData));

  cpRegXfer #(.CpNum(CpNum), .NumWaits(0)) dutZero_i (
    .clk(clk), .rstN(rstN), .reqN(reqN), .instr(instr), .condPass(condPass),
    .lateCancel(lateCancel), .hostWrData(hostWrData),
    .hsDecode(hsDecodeZ), .hsExec(hsExecZ), .cpRdData(cpRdDataZ));

  function automatic logic [31:0] mk(input int cp, input logic rd, input logic [3:0] idx);
    return (32'(rd) << 20) | (32'(idx) << 16) | (32'(cp & 15) << 8);
  endfunction

  localparam logic [31:0] Nop = 32'h0000_0000;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic rq, input logic [31:0] ins, input logic cp,
                     input logic lc, input logic [31:0] wd);
    @(negedge clk);
    reqN = rq; instr = ins; condPass = cp; lateCancel = lc; hostWrData = wd;
    #1;
  endtask

  // one transfer on the two-wait instance; got = read data in memory stage
  task automatic xfer(input logic rd, input logic [3:0] idx, input logic [31:0] wd,
                      input logic pass, input logic lc, output logic [31:0] got);
    cyc(0, mk(CpNum, rd, idx), 0, 0, 0);
    chk("R1 decode wait", 32'(hsDecode), 32'(WT));
    cyc(0, Nop, pass, 0, 0);
    cyc(1, Nop, 0, 0, 0);
    if (pass) chk("R4 first exec wait", 32'(hsExec), 32'(WT));
    else      chk("R3 dropped exec absent", 32'(hsExec), 32'(ABS));
    cyc(1, Nop, 0, 0, 0);
    if (pass) chk("R4 last", 32'(hsExec), 32'(LST));
    cyc(1, Nop, 0, lc, 0);
    got = cpRdData;
    cyc(1, Nop, 0, 0, wd);
    cyc(1, Nop, 0, 0, 0);
  endtask

  task automatic t_reset;
    logic [31:0] got;
    chk("R10 decode absent", 32'(hsDecode), 32'(ABS));
    chk("R10 exec absent", 32'(hsExec), 32'(ABS));
    chk("R10 read zero", cpRdData, 32'h0);
    xfer(1, 4'd3, 0, 1, 0, got);
    chk("R10 register zero", got, 32'h0);
  endtask

  task automatic t_writeRead;
    logic [31:0] got;
    xfer(0, 4'd3, 32'hA5A5_1234, 1, 0, got);
    chk("R6 zero outside read", got, 32'h0);
    xfer(1, 4'd3, 0, 1, 0, got);
    chk("R5 R6 readback r3", got, 32'hA5A5_1234);
    xfer(0, 4'd12, 32'hFFFF_0001, 1, 0, got);
    xfer(1, 4'd12, 0, 1, 0, got);
    chk("R2 readback r12", got, 32'hFFFF_0001);
    xfer(1, 4'd3, 0, 1, 0, got);
    chk("R2 r3 untouched", got, 32'hA5A5_1234);
  endtask

  task automatic t_foreign;
    cyc(0, mk(2, 1, 4'd3), 0, 0, 0);
    chk("R1 foreign absent", 32'(hsDecode), 32'(ABS));
    cyc(0, Nop, 1, 0, 0);
    cyc(1, Nop, 0, 0, 0);
    chk("R1 foreign no exec", 32'(hsExec), 32'(ABS));
    cyc(1, Nop, 0, 0, 0);
    chk("R1 foreign no data", cpRdData, 32'h0);
  endtask

  task automatic t_condFail;
    logic [31:0] got;
    xfer(0, 4'd4, 32'hDEAD_BEEF, 0, 0, got);
    xfer(1, 4'd4, 0, 0, 0, got);
    chk("R3 dropped read no data", got, 32'h0);
    xfer(1, 4'd4, 0, 1, 0, got);
    chk("R3 dropped write no effect", got, 32'h0);
  endtask

  task automatic t_cancel;
    logic [31:0] got;
    xfer(0, 4'd5, 32'h1111_1111, 1, 0, got);
    xfer(0, 4'd5, 32'h2222_2222, 1, 1, got);
    xfer(1, 4'd5, 0, 1, 0, got);
    chk("R7 cancelled write", got, 32'h1111_1111);
  endtask

  task automatic t_overlap;
    cyc(0, mk(CpNum, 0, 4'd7), 0, 0, 0);
    cyc(0, mk(CpNum, 1, 4'd7), 1, 0, 0);
    chk("R8 second decode", 32'(hsDecode), 32'(WT));
    cyc(1, Nop, 0, 0, 0);
    chk("R8 first wait", 32'(hsExec), 32'(WT));
    cyc(1, Nop, 0, 0, 0);
    cyc(0, Nop, 1, 0, 0);
    cyc(1, Nop, 0, 0, 32'h7777_0007);
    chk("R8 second wait", 32'(hsExec), 32'(WT));
    cyc(1, Nop, 0, 0, 0);
    chk("R8 second last", 32'(hsExec), 32'(LST));
    cyc(1, Nop, 0, 0, 0);
    chk("R8 read after overlap", cpRdData, 32'h7777_0007);
    cyc(1, Nop, 0, 0, 0);
  endtask

  task automatic t_zeroWait;
    cyc(0, mk(CpNum, 0, 4'd9), 0, 0, 0);
    chk("R1 zero-wait last", 32'(hsDecodeZ), 32'(LST));
    cyc(0, mk(CpNum, 1, 4'd9), 1, 0, 0);
    chk("R4 zero-wait exec absent", 32'(hsExecZ), 32'(ABS));
    cyc(0, Nop, 1, 0, 0);
    cyc(1, Nop, 0, 0, 32'hC0DE_0909);
    chk("R9 forwarded", cpRdDataZ, 32'hC0DE_0909);
    cyc(1, Nop, 0, 0, 0);
    cyc(1, Nop, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset_pre: chk("R10 in reset", cpRdData, 32'h0);
    rstN = 1'b1;
    t_reset();
    t_writeRead();
    t_foreign();
    t_condFail();
    t_cancel();
    t_overlap();
    t_zeroWait();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(ClkPeriod * 20000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule